// File: doc/BRIEF.md
# Supply Reset and Watchdog Supervisor

This block produces the system reset for a processor subsystem. It watches a digital undervoltage flag from an external comparator, the level read back from a shared reset pin, and a watchdog service input. It drives one reset output. A parameter sets whether that output is active-high or active-low. Reset is held while the supply is low and is stretched for a fixed timeout once the supply recovers. The same stretch applies when some other agent pulls the reset pin to its active level, and when software fails to service the watchdog in time.

The block also hands the memory write logic a lockout flag, which is set while the filtered supply flag reports undervoltage. Short spikes on the undervoltage flag are filtered out before they can reach either the reset or the lockout.

All durations are clock-cycle counts. By default they are derived from a clock-frequency parameter: a 200 ms stretch, a 1.6 s watchdog period and a 100 ns glitch window. A bench can override them with small values.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst_n` is low, `rst_out` is at its active level and `wr_lock` is 0.
- R2: After `rst_n` is released with `uv_in` low, reset stays active for exactly STRETCH_CYC rising clock edges and is inactive after the STRETCH_CYC-th edge.
- R3: When `uv_in` is sampled high on GLITCH_CYC consecutive edges, reset becomes active right after the last of those edges.
- R4: Once `uv_in` is sampled low, reset is released exactly STRETCH_CYC edges after the first edge that samples it low.
- R5: A high pulse on `uv_in` that spans fewer than GLITCH_CYC sampling edges changes neither `rst_out` nor `wr_lock`.
- R6: If `pin_sense` reads the active reset level on an edge while the block itself is not asserting reset, reset becomes active after that edge and is released STRETCH_CYC edges later. The active level is 1 when ACTIVE_HIGH=1 and 0 when ACTIVE_HIGH=0.
- R7: If reset is inactive and no watchdog service is sampled, reset becomes active WDOG_CYC edges after the edge on which reset was released. It is then stretched for STRETCH_CYC edges.
- R8: A change of level on `wd_kick` between two edges counts as a service. It restarts the watchdog period, so the next bite comes WDOG_CYC edges after the edge that sampled the change.
- R9: The watchdog count stays at zero while reset is active. The period after any release therefore always starts from zero.
- R10: `wr_lock` rises on the same edge on which a brown-out asserts reset. It falls on the first edge that samples `uv_in` low, even while reset is still being stretched.
- R11: With ACTIVE_HIGH=1, `rst_out` is 1 while in reset. With ACTIVE_HIGH=0, it is 0 while in reset. Timing is otherwise identical.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| uv_in | input | 1 | Undervoltage flag from the comparator, 1 = supply below threshold |
| pin_sense | input | 1 | Level read back from the shared reset pin |
| wd_kick | input | 1 | Watchdog service input; any level change is a service |
| rst_out | output | 1 | Reset drive, polarity set by ACTIVE_HIGH |
| wr_lock | output | 1 | Memory write lockout, 1 while the filtered supply flag reports undervoltage |

## Verification
The bound checker checks several relations on every cycle:
- the lockout never appears outside reset, and only follows a sampled undervoltage;
- a lockout never begins before the full glitch window of high samples;
- reset never releases before a full stretch of low supply samples;
- a watchdog bite always leads to reset;
- the watchdog count is zero after any reset cycle or service.

The exact cycle of each release and each bite can only be shown by the bench's scenarios. The same holds for the rejection of a short spike at the outputs, for the fact that a full period is restored after a bite, and for the agreement of the two polarity variants.

// File: rtl/sup_pkg.sv
package sup_pkg;

  // Cycles spanned by a duration in ns at a given clock; never less than one.
  function automatic int unsigned ns_to_cyc(longint unsigned hz, longint unsigned ns);
    longint unsigned c;
    c = (hz * ns) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return 32'(c);
  endfunction

  // Bits needed to hold values 0..n.
  function automatic int unsigned cnt_bits(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sup_uv_filter.sv
module sup_uv_filter #(
  parameter int unsigned GLITCH_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_in,
  output logic uv_flt
);
  localparam int unsigned GW = sup_pkg::cnt_bits(GLITCH_CYC);

  logic [GW-1:0] run;

  // Consecutive high samples, saturating at the window length.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     run <= '0;
    else if (!uv_in)                run <= '0;
    else if (run != GW'(GLITCH_CYC)) run <= run + 1'b1;
  end

  assign uv_flt = (run == GW'(GLITCH_CYC));
endmodule

// File: rtl/sup_stretch.sv
module sup_stretch #(
  parameter int unsigned STRETCH_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int unsigned SW = sup_pkg::cnt_bits(STRETCH_CYC);

  logic [SW-1:0] left;

  // Starts full so power-up behaves like any other reset cause.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          left <= SW'(STRETCH_CYC);
    else if (load)       left <= SW'(STRETCH_CYC);
    else if (left != '0) left <= left - 1'b1;
  end

  assign busy = (left != '0);
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
  parameter int unsigned WDOG_CYC = 64,
  parameter int unsigned WW       = sup_pkg::cnt_bits(WDOG_CYC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          wd_kick,
  output logic          kick_edge,
  output logic          bite,
  output logic [WW-1:0] count
);
  logic kick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kick_q <= 1'b0;
    else        kick_q <= wd_kick;
  end

  assign kick_edge = wd_kick ^ kick_q;
  assign bite      = !hold && !kick_edge && (count == WW'(WDOG_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          count <= '0;
    else if (hold || kick_edge || bite)  count <= '0;
    else                                 count <= count + 1'b1;
  end
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter bit              ACTIVE_HIGH = 1'b0,
  parameter longint unsigned CLK_HZ      = 200_000_000,
  parameter int unsigned     STRETCH_CYC = sup_pkg::ns_to_cyc(CLK_HZ, 200_000_000),
  parameter int unsigned     WDOG_CYC    = sup_pkg::ns_to_cyc(CLK_HZ, 1_600_000_000),
  parameter int unsigned     GLITCH_CYC  = sup_pkg::ns_to_cyc(CLK_HZ, 100)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_in,
  input  logic pin_sense,
  input  logic wd_kick,
  output logic rst_out,
  output logic wr_lock
);
  localparam int unsigned WW = sup_pkg::cnt_bits(WDOG_CYC);

  logic          uv_flt;
  logic          busy;
  logic          rst_act;
  logic          ext_lvl;
  logic          wd_bite;
  logic          kick_edge;
  logic [WW-1:0] wd_cnt;
  logic          pin_act;

  sup_uv_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .uv_in(uv_in), .uv_flt(uv_flt)
  );

  // Own drive is visible on the pin, so the readback is only honoured when idle.
  assign pin_act = ACTIVE_HIGH ? pin_sense : !pin_sense;
  assign ext_lvl = pin_act && !rst_act;

  sup_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_str (
    .clk(clk), .rst_n(rst_n), .load(uv_flt | wd_bite | ext_lvl), .busy(busy)
  );

  assign rst_act = uv_flt | busy;

  sup_wdog #(.WDOG_CYC(WDOG_CYC), .WW(WW)) u_wd (
    .clk(clk), .rst_n(rst_n), .hold(rst_act), .wd_kick(wd_kick),
    .kick_edge(kick_edge), .bite(wd_bite), .count(wd_cnt)
  );

  generate
    if (ACTIVE_HIGH) begin : g_hi
      assign rst_out = rst_act;
    end else begin : g_lo
      assign rst_out = !rst_act;
    end
  endgenerate

  assign wr_lock = uv_flt;
endmodule

// File: rtl/sup_checker.sv
module sup_checker #(
  parameter int unsigned STRETCH_CYC = 16,
  parameter int unsigned GLITCH_CYC  = 4,
  parameter int unsigned WW          = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          uv_in,
  input logic          wr_lock,
  input logic          rst_act,
  input logic          wd_bite,
  input logic          kick_edge,
  input logic [WW-1:0] wd_cnt
);
  localparam int unsigned SW = sup_pkg::cnt_bits(STRETCH_CYC);
  localparam int unsigned GW = sup_pkg::cnt_bits(GLITCH_CYC);

  logic [SW-1:0] lo_run;
  logic [GW-1:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           lo_run <= '0;
    else if (uv_in)                       lo_run <= '0;
    else if (lo_run != SW'(STRETCH_CYC))  lo_run <= lo_run + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           hi_run <= '0;
    else if (!uv_in)                      hi_run <= '0;
    else if (hi_run != GW'(GLITCH_CYC))   hi_run <= hi_run + 1'b1;
  end

  // R3
  lock_in_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lock |-> rst_act);

  // R10
  lock_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_lock) |-> $past(uv_in));

  // R5
  glitch_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_lock) |-> (hi_run == GW'(GLITCH_CYC)));

  // R4
  release_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_act) |-> (lo_run == SW'(STRETCH_CYC)));

  // R7
  bite_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_bite |=> rst_act);

  // R9
  wd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_act |=> (wd_cnt == '0));

  // R8
  kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_edge |=> (wd_cnt == '0));
endmodule

bind rst_supervisor sup_checker #(
  .STRETCH_CYC(STRETCH_CYC), .GLITCH_CYC(GLITCH_CYC), .WW(WW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .uv_in(uv_in), .wr_lock(wr_lock),
  .rst_act(rst_act), .wd_bite(wd_bite), .kick_edge(kick_edge), .wd_cnt(wd_cnt)
);

// File: tb/sim_rst_supervisor.sv
`timescale 1ns/1ps
module sim_rst_supervisor;
  localparam int S = 16;
  localparam int W = 60;
  localparam int G = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uv_in = 1'b0;
  logic wd_kick = 1'b0;
  logic ext_on = 1'b0;
  logic pin0, pin1, rst_out0, rst_out1, lock0, lock1;
  int   cyc = 0;
  int   tests = 0;
  int   fails = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Open-drain pin models: the block or an outside agent can pull it active.
  assign pin0 = (!rst_out0 || ext_on) ? 1'b0 : 1'b1;
  assign pin1 = ( rst_out1 || ext_on) ? 1'b1 : 1'b0;

  rst_supervisor #(.ACTIVE_HIGH(1'b0), .STRETCH_CYC(S), .WDOG_CYC(W), .GLITCH_CYC(G)) u0 (
    .clk(clk), .rst_n(rst_n), .uv_in(uv_in), .pin_sense(pin0), .wd_kick(wd_kick),
    .rst_out(rst_out0), .wr_lock(lock0)
  );

  rst_supervisor #(.ACTIVE_HIGH(1'b1), .STRETCH_CYC(S), .WDOG_CYC(W), .GLITCH_CYC(G)) u1 (
    .clk(clk), .rst_n(rst_n), .uv_in(uv_in), .pin_sense(pin1), .wd_kick(wd_kick),
    .rst_out(rst_out1), .wr_lock(lock1)
  );

  typedef struct {
    int    at;
    bit    act;
    bit    lock;
    string tag;
  } exp_t;

  exp_t sbq[$];

  task automatic expect_at(input int at, input bit act, input bit lock, input string tag);
    exp_t e;
    e.at = at; e.act = act; e.lock = lock; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].at <= cyc) begin
      exp_t e;
      e = sbq.pop_front();
      tests++;
      if (e.at < cyc) begin
        fails++;
        $display("FAIL %s: expectation for cycle %0d missed (now %0d, expected on time)", e.tag, e.at, cyc);
      end else if (rst_out0 !== !e.act || rst_out1 !== e.act || lock0 !== e.lock || lock1 !== e.lock) begin
        fails++;
        $display("FAIL %s (R11 polarity) @%0d: rst_lo=%b rst_hi=%b lock=%b/%b expected rst_lo=%b rst_hi=%b lock=%b",
                 e.tag, cyc, rst_out0, rst_out1, lock0, lock1, !e.act, e.act, e.lock);
      end
    end
  end

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: run hung, actual cycle %0d expected end before 20000", cyc);
    summary();
    $finish;
  end

  initial begin
    int t, t2, ra, rb, rc, rd;
    repeat (3) @(negedge clk);
    // R1: reset state
    tests++;
    if (rst_out0 !== 1'b0 || rst_out1 !== 1'b1 || lock0 !== 1'b0) begin
      fails++;
      $display("FAIL R1: rst_lo=%b rst_hi=%b lock=%b expected 0 1 0", rst_out0, rst_out1, lock0);
    end
    rst_n = 1'b1;
    t = cyc;
    expect_at(t + S - 1, 1'b1, 1'b0, "R2 still stretching");
    expect_at(t + S,     1'b0, 1'b0, "R2 powerup release");
    ra = t + S;

    // R5: spike of G-1 samples
    wait_until(ra + 2);
    t = cyc;
    expect_at(t + G - 1, 1'b0, 1'b0, "R5 spike in progress");
    expect_at(t + G + 1, 1'b0, 1'b0, "R5 spike rejected");
    uv_in = 1'b1;
    wait_until(t + G - 1);
    uv_in = 1'b0;

    // R3, R10, R4: brown-out
    wait_until(t + G + 3);
    t = cyc;
    t2 = t + G + 6;
    expect_at(t + G - 1, 1'b0, 1'b0, "R3 before window full");
    expect_at(t + G,     1'b1, 1'b1, "R3 R10 brownout asserts");
    expect_at(t2,        1'b1, 1'b1, "R10 lock held");
    expect_at(t2 + 1,    1'b1, 1'b0, "R10 lock clears in stretch");
    expect_at(t2 + S,    1'b1, 1'b0, "R4 last stretch cycle");
    expect_at(t2 + S + 1, 1'b0, 1'b0, "R4 recovery release");
    uv_in = 1'b1;
    wait_until(t2);
    uv_in = 1'b0;
    ra = t2 + S + 1;

    // R6: one-cycle external pull
    wait_until(ra + 2);
    t = cyc;
    expect_at(t + 1,     1'b1, 1'b0, "R6 external asserts");
    expect_at(t + S,     1'b1, 1'b0, "R6 stretching");
    expect_at(t + S + 1, 1'b0, 1'b0, "R6 release");
    rb = t + 1 + S;
    // R7, R9: bites without service
    expect_at(rb + W - 1, 1'b0, 1'b0, "R7 before bite");
    expect_at(rb + W,     1'b1, 1'b0, "R7 bite");
    rc = rb + W + S;
    expect_at(rc - 1,     1'b1, 1'b0, "R7 bite stretching");
    expect_at(rc,         1'b0, 1'b0, "R7 bite release");
    expect_at(rc + W - 1, 1'b0, 1'b0, "R9 full period restored");
    expect_at(rc + W,     1'b1, 1'b0, "R9 second bite");
    ext_on = 1'b1;
    wait_until(t + 1);
    ext_on = 1'b0;

    // R8: serviced watchdog
    rd = rc + W + S;
    wait_until(rd + 5);
    for (int k = 0; k < 6; k++) begin
      t = cyc;
      wd_kick = ~wd_kick;
      if (k < 5) begin
        expect_at(t + W / 2 - 1, 1'b0, 1'b0, "R8 serviced no bite");
        wait_until(t + W / 2);
      end else begin
        expect_at(t + W,     1'b0, 1'b0, "R8 before bite after last service");
        expect_at(t + W + 1, 1'b1, 1'b0, "R8 bite after last service");
        wait_until(t + W + 3);
      end
    end

    summary();
    $finish;
  end
endmodule